// File: doc/BRIEF.md
# Bus Master Retry Exception Handler

This block is the exception part of a bus master's cycle controller. A small stand-in sequencer runs each master memory cycle through the states idle, T1, T2 and a hold state Th. In T2 it waits for one of several normal acknowledge inputs. A system bus-retry input can end the cycle instead. When a retry is taken, the block raises a one-cycle terminate-and-retry pulse. It then runs the same cycle again with the address, direction and write data it captured when the cycle first started.

Two configuration inputs shape how the retry input is seen. The first picks direct sampling on the clock edge that closes T2, or sampling through a two-flop synchronizer for a retry input that is not timed to the clock. Synchronized sampling is legal only when the bus interface runs in its asynchronous mode. The second input picks latched or unlatched handling. In latched mode a short retry pulse is enough: it sets a status flag, and the re-run waits until software clears that flag with a write-one-to-clear strobe. In unlatched mode the retry must still be present at the end of Th. If it is not, the exception is withdrawn and the cycle goes back to waiting for an acknowledge.

Top module: `bus_retry_ctrl`

## Requirements
- R1: After a synchronous reset, `state_o` is idle (2'b00), and `done_o`, `retry_go_o`, `retry_flag_o` and `cfg_err_o` are all 0.
- R2: The state encoding is idle=0, T1=1, T2=2, Th=3. A start request in idle captures address, direction and data and moves to T1, then T2. An acknowledge in T2 moves to Th, then to idle with `done_o` high for one cycle.
- R3: In T2, a retry that is seen on the same edge as any acknowledge bit wins: the cycle ends as a retry, never as a normal completion.
- R4: With synchronous sampling, the retry input value present at the clock edge that ends T2 decides the exception.
- R5: With synchronized sampling, the decision at the end of T2 uses the retry input as it was two rising edges earlier. A retry that arrives too late for the current cycle but stays asserted is taken in the following cycle.
- R6: Synchronized sampling selected while the bus interface is in synchronous mode raises `cfg_err_o` one cycle later. While it is set, no master cycle starts and `state_o` stays idle.
- R7: In unlatched mode a retry is taken only if it is still seen at the edge that ends Th. Otherwise the sequencer returns to T2 and waits for an acknowledge.
- R8: In latched mode `retry_flag_o` sets on the edge where the retry is recognised in T2, even if the retry input drops one cycle later.
- R9: `flag_clr_i` clears `retry_flag_o` at the next edge, and a set on the same edge wins. While the flag is set the sequencer stays idle and start requests are ignored.
- R10: A taken retry re-runs the cycle without a new start request. The re-run begins only once the flag is clear and the retry input is seen inactive. It drives the originally captured address and data, and start requests that arrive while it is pending are ignored.
- R11: `retry_go_o` pulses for exactly one cycle as Th ends for a taken retry, and it is never high together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus_async | input | 1 | Bus interface runs in asynchronous mode |
| cfg_retry_async | input | 1 | Retry input is sampled through the synchronizer |
| cfg_retry_latched | input | 1 | Latched retry handling |
| start_i | input | 1 | Request a new master cycle |
| addr_i | input | ADDR_W | Address of the requested cycle |
| wr_i | input | 1 | Direction of the requested cycle, 1 = write |
| wdata_i | input | DATA_W | Write data of the requested cycle |
| ack_i | input | N_ACK | Normal cycle-termination acknowledges |
| retry_i | input | 1 | System bus-retry request, active high |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the retry flag |
| state_o | output | 2 | Current bus state |
| bus_addr_o | output | ADDR_W | Address of the cycle in progress |
| bus_wr_o | output | 1 | Direction of the cycle in progress |
| bus_wdata_o | output | DATA_W | Write data of the cycle in progress |
| done_o | output | 1 | One-cycle pulse: cycle completed by acknowledge |
| retry_go_o | output | 1 | One-cycle pulse: cycle terminated for retry |
| retry_flag_o | output | 1 | Latched retry status |
| cfg_err_o | output | 1 | Illegal sampling configuration |

## Verification
The assertions assume that acknowledges only arrive while the sequencer is in T2. They also assume that the configuration inputs change only while the sequencer is idle with nothing pending, so a sampling mode never switches in the middle of a cycle. The stimulus waits for the reported state before it drives an acknowledge or a retry edge, and it changes configuration only between completed cycles. The flag-clear strobe is issued only after the flag has been seen set.

// File: rtl/bus_retry_pkg.sv
package bus_retry_pkg;
  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_T1   = 2'd1,
    BS_T2   = 2'd2,
    BS_TH   = 2'd3
  } bus_state_e;
endpackage

// File: rtl/retry_sampler.sv
module retry_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic retry_raw,
  input  logic use_async,
  output logic retry_eff
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= retry_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], retry_raw};
      end
    end
  endgenerate

  // Direct sample when synchronous, last synchronizer stage otherwise.
  assign retry_eff = use_async ? sync_q[TOP] : retry_raw;
endmodule

// File: rtl/retry_status.sv
module retry_status (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/master_cycle_seq.sv
module master_cycle_seq
  import bus_retry_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_any,
  input  logic              retry_eff,
  input  logic              latched,
  input  logic              blocked,
  input  logic              flag,
  output bus_state_e        state_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              done_o,
  output logic              retry_go_o,
  output logic              flag_set_o
);
  bus_state_e state_q;
  logic       term_retry_q;
  logic       pending_q;

  assign flag_set_o = (state_q == BS_T2) && retry_eff && latched;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= BS_IDLE;
      term_retry_q <= 1'b0;
      pending_q    <= 1'b0;
      done_o       <= 1'b0;
      retry_go_o   <= 1'b0;
      bus_addr_o   <= '0;
      bus_wr_o     <= 1'b0;
      bus_wdata_o  <= '0;
    end else begin
      done_o     <= 1'b0;
      retry_go_o <= 1'b0;
      case (state_q)
        BS_IDLE: begin
          if (!blocked) begin
            if (pending_q) begin
              if (!flag && !retry_eff) begin
                pending_q <= 1'b0;
                state_q   <= BS_T1;
              end
            end else if (start_i && !flag) begin
              bus_addr_o  <= addr_i;
              bus_wr_o    <= wr_i;
              bus_wdata_o <= wdata_i;
              state_q     <= BS_T1;
            end
          end
        end
        BS_T1: state_q <= BS_T2;
        BS_T2: begin
          if (retry_eff) begin
            term_retry_q <= 1'b1;
            state_q      <= BS_TH;
          end else if (ack_any) begin
            term_retry_q <= 1'b0;
            state_q      <= BS_TH;
          end
        end
        BS_TH: begin
          if (term_retry_q) begin
            if (latched || retry_eff) begin
              retry_go_o <= 1'b1;
              pending_q  <= 1'b1;
              state_q    <= BS_IDLE;
            end else begin
              term_retry_q <= 1'b0;
              state_q      <= BS_T2;
            end
          end else begin
            done_o  <= 1'b1;
            state_q <= BS_IDLE;
          end
        end
        default: state_q <= BS_IDLE;
      endcase
    end
  end

  assign state_o = state_q;

  // R3: a retry seen in T2 always ends the cycle as a retry
  p_retry_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == BS_T2 && retry_eff) |=> (state_q == BS_TH && term_retry_q));

  // R6: illegal configuration keeps the sequencer idle
  p_cfg_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == BS_IDLE && blocked) |=> (state_q == BS_IDLE));

  // R7: unlatched retry released before Th ends returns to T2
  p_drop_to_t2_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == BS_TH && term_retry_q && !latched && !retry_eff) |=> (state_q == BS_T2));

  // R9: no cycle starts while the status flag is set
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == BS_IDLE && flag) |=> (state_q == BS_IDLE));

  // R10: captured cycle attributes stay put once a cycle is under way
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q != BS_IDLE) |=> ($stable(bus_addr_o) && $stable(bus_wdata_o)));

  // R11: the two termination pulses never coincide
  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(done_o && retry_go_o));
endmodule

// File: rtl/bus_retry_ctrl.sv
module bus_retry_ctrl
  import bus_retry_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int N_ACK       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bus_async,
  input  logic              cfg_retry_async,
  input  logic              cfg_retry_latched,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_ACK-1:0]  ack_i,
  input  logic              retry_i,
  input  logic              flag_clr_i,
  output logic [1:0]        state_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              done_o,
  output logic              retry_go_o,
  output logic              retry_flag_o,
  output logic              cfg_err_o
);
  logic       retry_eff;
  logic       flag_set;
  logic       use_async;
  bus_state_e seq_state;

  assign use_async = cfg_retry_async && cfg_bus_async;

  always_ff @(posedge clk) begin
    if (rst) cfg_err_o <= 1'b0;
    else     cfg_err_o <= cfg_retry_async && !cfg_bus_async;
  end

  retry_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst       (rst),
    .retry_raw (retry_i),
    .use_async (use_async),
    .retry_eff (retry_eff)
  );

  retry_status u_status (
    .clk    (clk),
    .rst    (rst),
    .set_i  (flag_set),
    .clr_i  (flag_clr_i),
    .flag_o (retry_flag_o)
  );

  master_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .wdata_i     (wdata_i),
    .ack_any     (|ack_i),
    .retry_eff   (retry_eff),
    .latched     (cfg_retry_latched),
    .blocked     (cfg_err_o),
    .flag        (retry_flag_o),
    .state_o     (seq_state),
    .bus_addr_o  (bus_addr_o),
    .bus_wr_o    (bus_wr_o),
    .bus_wdata_o (bus_wdata_o),
    .done_o      (done_o),
    .retry_go_o  (retry_go_o),
    .flag_set_o  (flag_set)
  );

  assign state_o = seq_state;

  // R8: the flag only rises on the edge that closes T2
  p_flag_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(retry_flag_o) |-> ($past(seq_state) == BS_T2));
endmodule

// File: tb/bus_retry_ctrl_bench.sv
module bus_retry_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NA = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_bus_async = 1'b0, cfg_retry_async = 1'b0, cfg_retry_latched = 1'b0;
  logic start_i = 1'b0, wr_i = 1'b0, retry_i = 1'b0, flag_clr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [NA-1:0] ack_i = '0;
  logic [1:0] state_o;
  logic [AW-1:0] bus_addr_o;
  logic bus_wr_o, done_o, retry_go_o, retry_flag_o, cfg_err_o;
  logic [DW-1:0] bus_wdata_o;

  bus_retry_ctrl #(.ADDR_W(AW), .DATA_W(DW), .N_ACK(NA)) u_bus_retry_ctrl (
    .clk(clk), .rst(rst), .cfg_bus_async(cfg_bus_async),
    .cfg_retry_async(cfg_retry_async), .cfg_retry_latched(cfg_retry_latched),
    .start_i(start_i), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .ack_i(ack_i), .retry_i(retry_i), .flag_clr_i(flag_clr_i),
    .state_o(state_o), .bus_addr_o(bus_addr_o), .bus_wr_o(bus_wr_o),
    .bus_wdata_o(bus_wdata_o), .done_o(done_o), .retry_go_o(retry_go_o),
    .retry_flag_o(retry_flag_o), .cfg_err_o(cfg_err_o)
  );

  localparam logic [1:0] S_IDLE = 2'd0, S_T1 = 2'd1, S_T2 = 2'd2, S_TH = 2'd3;

  typedef struct packed { logic is_retry; logic [AW-1:0] addr; } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(logic [1:0] s, string tag);
    for (int k = 0; k < 40 && state_o != s; k++) @(negedge clk);
    chk(state_o == s, tag, 64'(state_o), 64'(s));
  endtask

  // Driver: request a cycle; returns at the negedge where T1 is visible.
  task automatic launch(logic [AW-1:0] a);
    start_i = 1'b1; addr_i = a; wr_i = 1'b1; wdata_i = {a, ~a};
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic push(logic is_retry, logic [AW-1:0] a);
    exp_t e;
    e.is_retry = is_retry; e.addr = a;
    sb.push_back(e);
  endtask

  // Acknowledge in T2 and let the cycle finish.
  task automatic finish_with_ack(logic [NA-1:0] pattern);
    wait_state(S_T2, "R2 reach T2");
    ack_i = pattern;
    step(1);
    ack_i = '0;
    step(1);
  endtask

  // Monitor: pop the scoreboard on every termination pulse.
  always @(negedge clk) begin
    exp_t e;
    if (!rst && (done_o || retry_go_o)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected termination", {retry_go_o, done_o}, 0);
      end else begin
        e = sb.pop_front();
        chk(e.is_retry == retry_go_o && (done_o != retry_go_o) && e.addr == bus_addr_o,
            "R10 scoreboard termination kind/address",
            {done_o, retry_go_o, bus_addr_o}, {~e.is_retry, e.is_retry, e.addr});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    // R1 reset state
    chk(state_o == S_IDLE && !done_o && !retry_go_o && !retry_flag_o && !cfg_err_o,
        "R1 reset outputs", {state_o, done_o, retry_go_o, retry_flag_o, cfg_err_o}, 0);

    // R2 / R4 plain synchronous cycle
    push(1'b0, 16'h1234);
    launch(16'h1234);
    chk(state_o == S_T1, "R2 T1 after start", state_o, S_T1);
    step(1);
    chk(state_o == S_T2, "R2 T2 after T1", state_o, S_T2);
    ack_i = 3'b010;
    step(1);
    chk(state_o == S_TH, "R2 Th after ack", state_o, S_TH);
    ack_i = '0;
    step(1);
    chk(done_o && state_o == S_IDLE, "R2 done pulse", {done_o, state_o}, {1'b1, S_IDLE});

    // R3 / R4 / R11 / R10: unlatched retry together with every ack
    push(1'b1, 16'h2222); push(1'b0, 16'h2222);
    launch(16'h2222);
    wait_state(S_T2, "R4 reach T2");
    ack_i = 3'b111; retry_i = 1'b1;
    step(1);
    ack_i = '0;
    chk(state_o == S_TH, "R3 retry beats ack", state_o, S_TH);
    step(1);
    chk(retry_go_o && state_o == S_IDLE, "R11 retry pulse", {retry_go_o, state_o}, {1'b1, S_IDLE});
    start_i = 1'b1; addr_i = 16'h9999;
    step(1);
    start_i = 1'b0;
    step(1);
    chk(state_o == S_IDLE, "R10 replay waits for retry release", state_o, S_IDLE);
    retry_i = 1'b0;
    wait_state(S_T2, "R10 replay reaches T2");
    chk(bus_addr_o == 16'h2222 && bus_wdata_o == {16'h2222, ~16'h2222},
        "R10 replay reuses captured cycle", bus_addr_o, 16'h2222);
    finish_with_ack(3'b001);

    // R7 unlatched retry released before end of Th
    push(1'b0, 16'h3333);
    launch(16'h3333);
    wait_state(S_T2, "R7 reach T2");
    retry_i = 1'b1;
    step(1);
    retry_i = 1'b0;
    step(1);
    chk(state_o == S_T2 && !retry_go_o, "R7 dropped retry returns to T2",
        {retry_go_o, state_o}, {1'b0, S_T2});
    finish_with_ack(3'b100);

    // R8 / R9 latched synchronous retry
    cfg_retry_latched = 1'b1;
    push(1'b1, 16'h4444); push(1'b0, 16'h4444);
    launch(16'h4444);
    wait_state(S_T2, "R8 reach T2");
    retry_i = 1'b1;
    step(1);
    retry_i = 1'b0;
    chk(retry_flag_o == 1'b1, "R8 flag set at recognition", retry_flag_o, 1);
    step(1);
    start_i = 1'b1; addr_i = 16'h5555;
    step(3);
    start_i = 1'b0;
    chk(state_o == S_IDLE && retry_flag_o, "R9 idle while flag set",
        {retry_flag_o, state_o}, {1'b1, S_IDLE});
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
    chk(retry_flag_o == 1'b0, "R9 write-one-to-clear", retry_flag_o, 0);
    wait_state(S_T2, "R10 latched replay reaches T2");
    chk(bus_addr_o == 16'h4444, "R10 latched replay address", bus_addr_o, 16'h4444);
    finish_with_ack(3'b010);

    // R5 synchronized sampling: late retry misses current cycle
    cfg_bus_async = 1'b1; cfg_retry_async = 1'b1;
    step(1);
    push(1'b0, 16'h6666);
    launch(16'h6666);
    wait_state(S_T2, "R5 reach T2");
    ack_i = 3'b001; retry_i = 1'b1;
    step(1);
    ack_i = '0;
    chk(retry_flag_o == 1'b0, "R5 late retry not taken in current cycle", retry_flag_o, 0);
    step(1);
    // retry still high: taken in the following cycle
    push(1'b1, 16'h7777); push(1'b0, 16'h7777);
    launch(16'h7777);
    wait_state(S_T2, "R5 next cycle T2");
    step(1);
    chk(retry_flag_o == 1'b1 && state_o == S_TH, "R5 retry taken in following cycle",
        {retry_flag_o, state_o}, {1'b1, S_TH});
    retry_i = 1'b0;
    step(1);
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
    finish_with_ack(3'b100);

    // R5 early synchronized retry is taken in the current cycle
    push(1'b1, 16'h8888); push(1'b0, 16'h8888);
    retry_i = 1'b1;
    launch(16'h8888);
    retry_i = 1'b0;
    wait_state(S_T2, "R5 early reach T2");
    step(1);
    chk(retry_flag_o == 1'b1, "R5 early retry taken in current cycle", retry_flag_o, 1);
    step(1);
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
    finish_with_ack(3'b010);

    // R6 illegal configuration
    cfg_bus_async = 1'b0;
    step(2);
    chk(cfg_err_o == 1'b1, "R6 illegal config flagged", cfg_err_o, 1);
    launch(16'hAAAA);
    chk(state_o == S_IDLE, "R6 start ignored under illegal config", state_o, S_IDLE);
    step(2);
    chk(state_o == S_IDLE && !done_o, "R6 still idle", {done_o, state_o}, 0);
    cfg_retry_async = 1'b0;
    step(2);
    chk(cfg_err_o == 1'b0, "R6 error clears with legal config", cfg_err_o, 0);

    step(2);
    chk(sb.size() == 0, "R11 all expected terminations seen", sb.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule